// File: doc/BRIEF.md
# Status Word and Banked Stack Pointer Unit

This block holds a processor's status word and the stack pointers that go with it. The status word has three fields: a 6-bit condition byte, a 3-bit system control field and a 5-bit interrupt level mask. The condition byte carries the arithmetic flags, an interrupt enable and a stack select bit. The block holds one live stack pointer and two shadow copies. One shadow belongs to system mode and the other to user mode. The stack select bit decides which of the two the live register stands in for.

Each field, and the whole status word, has its own write port. The live stack pointer has a direct write port. Six dedicated registers are reached through a single select-indexed read/write port: the table base, the return pointer, the system and user stack pointers, and the multiply/divide high and low words. When stack select changes, the live pointer is swapped with the proper shadow. Accesses to the banked stack pointers through the dedicated port are steered to wherever that pointer currently lives. Once the interrupt level mask is in the upper half of its range, it can never be lowered below 16.

Top module: `status_stack_unit`

## Requirements
- R1: After reset the status word reads 0, stack select is 0 (system stack in use), and the live pointer, both banked pointers and all plain dedicated registers read 0.
- R2: A condition byte write stores only bits 5:0 of its data. Bit 0 is carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 interrupt enable and bit 5 stack select. Bits 7:6 of the condition output read 0.
- R3: A control field write stores only bits 2:0 of its data. Bit 0 is trace and bits 2:1 are the two step-division flags.
- R4: The status word output carries the condition byte in bits 7:0, the control field in bits 10:8 and the level mask in bits 20:16; every other bit reads 0. A status-word write takes each field from those same positions. A field write in the same cycle wins over the status-word write for that field.
- R5: When the current level mask is 16 or more and the value written (through either port) is below 16, the stored value is the written value plus 16; otherwise the written value is stored unchanged.
- R6: When stack select goes from 0 to 1, the old live pointer is saved into the system shadow and the live pointer is loaded from the user shadow.
- R7: When stack select goes from 1 to 0, the old live pointer is saved into the user shadow and the live pointer is loaded from the system shadow.
- R8: Writing stack select with its current value leaves the live pointer and both shadows unchanged.
- R9: Dedicated select code 2 is the system stack pointer and code 3 the user stack pointer. A read or write of code 2 while stack select is 0, or of code 3 while stack select is 1, goes to the live pointer; otherwise it goes to that pointer's shadow. A dedicated write in the same cycle as a stack select change is dropped for the banked pointers.
- R10: Dedicated codes 0 (table base), 1 (return pointer), 4 (multiply/divide high) and 5 (multiply/divide low) are plain storage in every mode. Codes 6 and 7 read 0 and writes to them change nothing.
- R11: If a stack select change and a direct live-pointer write fall in the same cycle, the swap follows the new select value. The direct write data wins for the live pointer, and the saved shadow receives the old live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psw_we_i | input | 1 | Whole status word write enable |
| psw_wdata_i | input | 32 | Status word write data |
| cond_we_i | input | 1 | Condition byte write enable |
| cond_wdata_i | input | 8 | Condition byte write data |
| ctrl_we_i | input | 1 | Control field write enable |
| ctrl_wdata_i | input | 8 | Control field write data |
| lvl_we_i | input | 1 | Level mask write enable |
| lvl_wdata_i | input | 5 | Level mask write data |
| sp_we_i | input | 1 | Live stack pointer write enable |
| sp_wdata_i | input | XLEN | Live stack pointer write data |
| dr_we_i | input | 1 | Dedicated register write enable |
| dr_sel_i | input | 3 | Dedicated register select |
| dr_wdata_i | input | XLEN | Dedicated register write data |
| psw_o | output | 32 | Composed status word |
| cond_o | output | 8 | Condition byte |
| ctrl_o | output | 3 | Control field |
| lvl_o | output | 5 | Interrupt level mask |
| sp_o | output | XLEN | Live stack pointer |
| dr_rdata_o | output | XLEN | Dedicated register read data (combinational on select) |

## Verification
The bench walks the level mask across the 16 boundary in both directions. A design that compared against the written value, or against the next value, would let the mask drop, or would add 16 when it should not. It toggles stack select through both the condition port and the status-word port, and writes the same value again. A swap built on the wrong shadow, or one that fires on a plain rewrite, shows up as a wrong live pointer or wrong banked read-back. It reads both banked pointers through the dedicated port in each mode to catch steering inverted by select, and it collides a select change with a direct pointer write to pin down which value wins the live register and which one reaches the shadow.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int PSW_W     = 32;
  localparam int COND_W    = 6;
  localparam int CTRL_W    = 3;
  localparam int LVL_W     = 5;
  localparam int CTRL_LSB  = 8;
  localparam int LVL_LSB   = 16;
  localparam int SEL_BIT   = 5;
  localparam int LVL_FLOOR = 16;
  localparam int DR_SEL_W  = 3;
  localparam int NPLAIN    = 4;

  typedef enum logic [DR_SEL_W-1:0] {
    DR_TBASE  = 3'd0,
    DR_RETP   = 3'd1,
    DR_SYS_SP = 3'd2,
    DR_USR_SP = 3'd3,
    DR_MULH   = 3'd4,
    DR_MULL   = 3'd5
  } dr_sel_e;
endpackage

// File: rtl/ssu_status_reg.sv
module ssu_status_reg
  import ssu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psw_we_i,
  input  logic [PSW_W-1:0]  psw_wdata_i,
  input  logic              cond_we_i,
  input  logic [7:0]        cond_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              lvl_we_i,
  input  logic [LVL_W-1:0]  lvl_wdata_i,
  output logic [COND_W-1:0] cond_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              sel_q_o,
  output logic              sel_d_o
);
  logic [COND_W-1:0] cond_q, cond_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d, lvl_wr;
  logic              lvl_wr_en;
  logic              unused_bits;

  assign unused_bits = ^{psw_wdata_i[PSW_W-1:LVL_LSB+LVL_W],
                         psw_wdata_i[LVL_LSB-1:CTRL_LSB+CTRL_W],
                         psw_wdata_i[CTRL_LSB-1:COND_W],
                         cond_wdata_i[7:COND_W], ctrl_wdata_i[7:CTRL_W]};

  always_comb begin
    cond_d = cond_q;
    ctrl_d = ctrl_q;
    lvl_wr = lvl_q;
    if (psw_we_i) begin
      cond_d = psw_wdata_i[COND_W-1:0];
      ctrl_d = psw_wdata_i[CTRL_LSB +: CTRL_W];
      lvl_wr = psw_wdata_i[LVL_LSB +: LVL_W];
    end
    if (cond_we_i) cond_d = cond_wdata_i[COND_W-1:0];
    if (ctrl_we_i) ctrl_d = ctrl_wdata_i[CTRL_W-1:0];
    if (lvl_we_i)  lvl_wr = lvl_wdata_i;
  end

  assign lvl_wr_en = psw_we_i | lvl_we_i;

  // mask may not leave the upper half once there
  always_comb begin
    lvl_d = lvl_q;
    if (lvl_wr_en) begin
      if (int'(lvl_q) >= LVL_FLOOR && int'(lvl_wr) < LVL_FLOOR)
        lvl_d = lvl_wr + LVL_W'(LVL_FLOOR);
      else
        lvl_d = lvl_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      ctrl_q <= '0;
      lvl_q  <= '0;
    end else begin
      cond_q <= cond_d;
      ctrl_q <= ctrl_d;
      lvl_q  <= lvl_d;
    end
  end

  assign cond_o  = cond_q;
  assign ctrl_o  = ctrl_q;
  assign lvl_o   = lvl_q;
  assign sel_q_o = cond_q[SEL_BIT];
  assign sel_d_o = cond_d[SEL_BIT];

  // R5: mask never falls back below the floor
  a_r5_lvl_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lvl_q) >= LVL_FLOOR) |=> (int'(lvl_q) >= LVL_FLOOR));
  // R5: without a write the mask holds
  a_r5_lvl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psw_we_i && !lvl_we_i) |=> $stable(lvl_q));
endmodule

// File: rtl/ssu_stack_bank.sv
module ssu_stack_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_q_i,
  input  logic            sel_d_i,
  input  logic            sp_we_i,
  input  logic [XLEN-1:0] sp_wdata_i,
  input  logic            sys_we_i,
  input  logic            usr_we_i,
  input  logic [XLEN-1:0] bank_wdata_i,
  output logic [XLEN-1:0] live_o,
  output logic [XLEN-1:0] sys_rd_o,
  output logic [XLEN-1:0] usr_rd_o
);
  logic [XLEN-1:0] live_q, live_d, sys_q, sys_d, usr_q, usr_d;
  logic            swap;

  assign swap = sel_d_i ^ sel_q_i;

  always_comb begin
    live_d = live_q;
    sys_d  = sys_q;
    usr_d  = usr_q;
    if (swap) begin
      if (sel_d_i) begin
        sys_d  = live_q;
        live_d = usr_q;
      end else begin
        usr_d  = live_q;
        live_d = sys_q;
      end
    end else begin
      if (sys_we_i) begin
        if (sel_q_i) sys_d = bank_wdata_i;
        else         live_d = bank_wdata_i;
      end
      if (usr_we_i) begin
        if (sel_q_i) live_d = bank_wdata_i;
        else         usr_d = bank_wdata_i;
      end
    end
    if (sp_we_i) live_d = sp_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      sys_q  <= '0;
      usr_q  <= '0;
    end else begin
      live_q <= live_d;
      sys_q  <= sys_d;
      usr_q  <= usr_d;
    end
  end

  assign live_o   = live_q;
  assign sys_rd_o = sel_q_i ? sys_q : live_q;
  assign usr_rd_o = sel_q_i ? live_q : usr_q;

  // R6: entering user stack saves the live pointer to the system shadow
  a_r6_save_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q_i && sel_d_i) |=> (sys_q == $past(live_q)));
  // R6: and loads the user shadow when no direct write collides
  a_r6_load_usr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q_i && sel_d_i && !sp_we_i) |=> (live_q == $past(usr_q)));
  // R7: leaving user stack saves into the user shadow
  a_r7_save_usr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_i && !sel_d_i) |=> (usr_q == $past(live_q)));
  // R11: direct write always wins the live register
  a_r11_direct_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_i |=> (live_o == $past(sp_wdata_i)));
  // R8: no select change and no writes keep all pointers
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap && !sp_we_i && !sys_we_i && !usr_we_i) |=>
      ($stable(live_q) && $stable(sys_q) && $stable(usr_q)));
endmodule

// File: rtl/ssu_dedicated_regs.sv
module ssu_dedicated_regs
  import ssu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DR_SEL_W-1:0] sel_i,
  input  logic [XLEN-1:0]     wdata_i,
  output logic                hit_o,
  output logic [XLEN-1:0]     rdata_o
);
  logic [XLEN-1:0] regs_q [NPLAIN];
  logic [$clog2(NPLAIN)-1:0] idx;

  always_comb begin
    hit_o = 1'b1;
    idx   = '0;
    unique case (sel_i)
      DR_TBASE: idx = 2'd0;
      DR_RETP:  idx = 2'd1;
      DR_MULH:  idx = 2'd2;
      DR_MULL:  idx = 2'd3;
      default:  hit_o = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && hit_o && int'(idx) == g)     regs_q[g] <= wdata_i;
    end
    // R10: a plain register only changes under its own write
    a_r10_plain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && hit_o && int'(idx) == g) |=> $stable(regs_q[g]));
  end

  assign rdata_o = hit_o ? regs_q[idx] : '0;
endmodule

// File: rtl/status_stack_unit.sv
module status_stack_unit
  import ssu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psw_we_i,
  input  logic [PSW_W-1:0]    psw_wdata_i,
  input  logic                cond_we_i,
  input  logic [7:0]          cond_wdata_i,
  input  logic                ctrl_we_i,
  input  logic [7:0]          ctrl_wdata_i,
  input  logic                lvl_we_i,
  input  logic [LVL_W-1:0]    lvl_wdata_i,
  input  logic                sp_we_i,
  input  logic [XLEN-1:0]     sp_wdata_i,
  input  logic                dr_we_i,
  input  logic [DR_SEL_W-1:0] dr_sel_i,
  input  logic [XLEN-1:0]     dr_wdata_i,
  output logic [PSW_W-1:0]    psw_o,
  output logic [7:0]          cond_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [LVL_W-1:0]    lvl_o,
  output logic [XLEN-1:0]     sp_o,
  output logic [XLEN-1:0]     dr_rdata_o
);
  logic [COND_W-1:0] cond;
  logic              sel_q, sel_d;
  logic              sys_we, usr_we, plain_hit;
  logic [XLEN-1:0]   sys_rd, usr_rd, plain_rd;

  ssu_status_reg u_status (
    .clk_i, .rst_ni,
    .psw_we_i, .psw_wdata_i,
    .cond_we_i, .cond_wdata_i,
    .ctrl_we_i, .ctrl_wdata_i,
    .lvl_we_i, .lvl_wdata_i,
    .cond_o (cond),
    .ctrl_o (ctrl_o),
    .lvl_o  (lvl_o),
    .sel_q_o(sel_q),
    .sel_d_o(sel_d)
  );

  assign sys_we = dr_we_i && (dr_sel_i == DR_SYS_SP);
  assign usr_we = dr_we_i && (dr_sel_i == DR_USR_SP);

  ssu_stack_bank #(.XLEN(XLEN)) u_stack (
    .clk_i, .rst_ni,
    .sel_q_i     (sel_q),
    .sel_d_i     (sel_d),
    .sp_we_i,
    .sp_wdata_i,
    .sys_we_i    (sys_we),
    .usr_we_i    (usr_we),
    .bank_wdata_i(dr_wdata_i),
    .live_o      (sp_o),
    .sys_rd_o    (sys_rd),
    .usr_rd_o    (usr_rd)
  );

  ssu_dedicated_regs #(.XLEN(XLEN)) u_dedicated (
    .clk_i, .rst_ni,
    .we_i   (dr_we_i),
    .sel_i  (dr_sel_i),
    .wdata_i(dr_wdata_i),
    .hit_o  (plain_hit),
    .rdata_o(plain_rd)
  );

  always_comb begin
    if (plain_hit)                    dr_rdata_o = plain_rd;
    else if (dr_sel_i == DR_SYS_SP)   dr_rdata_o = sys_rd;
    else if (dr_sel_i == DR_USR_SP)   dr_rdata_o = usr_rd;
    else                              dr_rdata_o = '0;
  end

  assign cond_o = {{(8-COND_W){1'b0}}, cond};
  always_comb begin
    psw_o = '0;
    psw_o[COND_W-1:0]            = cond;
    psw_o[CTRL_LSB +: CTRL_W]    = ctrl_o;
    psw_o[LVL_LSB +: LVL_W]      = lvl_o;
  end

  // R9: with system stack selected, the system pointer read is the live one
  a_r9_sys_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_o[SEL_BIT] && dr_sel_i == DR_SYS_SP) |-> (dr_rdata_o == sp_o));
  // R9: with user stack selected, the user pointer read is the live one
  a_r9_usr_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o[SEL_BIT] && dr_sel_i == DR_USR_SP) |-> (dr_rdata_o == sp_o));
endmodule

// File: tb/status_stack_unit_tb_top.sv
module status_stack_unit_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            psw_we = 0, cond_we = 0, ctrl_we = 0, lvl_we = 0, sp_we = 0, dr_we = 0;
  logic [31:0]     psw_wd = '0;
  logic [7:0]      cond_wd = '0, ctrl_wd = '0;
  logic [4:0]      lvl_wd = '0;
  logic [XLEN-1:0] sp_wd = '0, dr_wd = '0;
  logic [2:0]      dr_sel = '0;
  logic [31:0]     psw;
  logic [7:0]      cond;
  logic [2:0]      ctrl;
  logic [4:0]      lvl;
  logic [XLEN-1:0] sp, dr_rd;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  status_stack_unit #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .psw_we_i(psw_we), .psw_wdata_i(psw_wd),
    .cond_we_i(cond_we), .cond_wdata_i(cond_wd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .lvl_we_i(lvl_we), .lvl_wdata_i(lvl_wd),
    .sp_we_i(sp_we), .sp_wdata_i(sp_wd),
    .dr_we_i(dr_we), .dr_sel_i(dr_sel), .dr_wdata_i(dr_wd),
    .psw_o(psw), .cond_o(cond), .ctrl_o(ctrl), .lvl_o(lvl),
    .sp_o(sp), .dr_rdata_o(dr_rd)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    psw_we = 0; cond_we = 0; ctrl_we = 0; lvl_we = 0; sp_we = 0; dr_we = 0;
  endtask

  // each write helper drives at a falling edge and returns one cycle later
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_psw(input logic [31:0] v);
    @(negedge clk); psw_we = 1; psw_wd = v; step();
  endtask
  task automatic wr_cond(input logic [7:0] v);
    @(negedge clk); cond_we = 1; cond_wd = v; step();
  endtask
  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wd = v; step();
  endtask
  task automatic wr_lvl(input logic [4:0] v);
    @(negedge clk); lvl_we = 1; lvl_wd = v; step();
  endtask
  task automatic wr_sp(input logic [31:0] v);
    @(negedge clk); sp_we = 1; sp_wd = v; step();
  endtask
  task automatic wr_dr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk); dr_we = 1; dr_sel = s; dr_wd = v; step();
  endtask
  task automatic rd_dr(input string tag, input logic [2:0] s, input logic [31:0] exp);
    dr_sel = s; #1;
    check(tag, dr_rd, exp);
  endtask

  task automatic t_reset();
    check("R1 psw", psw, 32'h0);
    check("R1 sp", sp, 32'h0);
    for (int i = 0; i < 8; i++) rd_dr("R1 dedicated", 3'(i), 32'h0);
  endtask

  task automatic t_level();
    wr_lvl(5'd3);  check("R5 set 3", {27'd0, lvl}, 32'd3);
    wr_lvl(5'd12); check("R5 lower below 16", {27'd0, lvl}, 32'd12);
    wr_lvl(5'd20); check("R5 raise 20", {27'd0, lvl}, 32'd20);
    wr_lvl(5'd7);  check("R5 clamp 7", {27'd0, lvl}, 32'd23);
    wr_lvl(5'd17); check("R5 upper 17", {27'd0, lvl}, 32'd17);
  endtask

  task automatic t_word();
    wr_psw(32'hFFFF_FFFF);
    check("R4 psw all ones", psw, 32'h001F_073F);
    wr_psw(32'h0000_0000);
    check("R4 R5 psw zero clamps level", psw, 32'h0010_0000);
    @(negedge clk); psw_we = 1; psw_wd = 32'h0000_0500; ctrl_we = 1; ctrl_wd = 8'h03; step();
    check("R4 field write wins", psw, 32'h0010_0300);
  endtask

  task automatic t_fields();
    wr_cond(8'hDF);
    check("R2 cond mask", {24'd0, cond}, 32'h1F);
    check("R2 psw low byte", psw, 32'h0010_031F);
    wr_cond(8'h00);
    wr_ctrl(8'hFA);
    check("R3 ctrl mask", {29'd0, ctrl}, 32'h2);
    check("R3 psw ctrl bits", psw, 32'h0010_0200);
  endtask

  task automatic t_stack();
    wr_sp(32'hA1);
    rd_dr("R9 sys reads live", 3'd2, 32'hA1);
    rd_dr("R9 usr reads shadow", 3'd3, 32'h0);
    wr_dr(3'd3, 32'hB2);
    rd_dr("R9 usr shadow write", 3'd3, 32'hB2);
    check("R9 live untouched", sp, 32'hA1);
    wr_dr(3'd2, 32'hC3);
    check("R9 sys write hits live", sp, 32'hC3);
    wr_cond(8'h20);
    check("R6 live from user", sp, 32'hB2);
    rd_dr("R6 sys shadow saved", 3'd2, 32'hC3);
    rd_dr("R9 usr reads live", 3'd3, 32'hB2);
    wr_dr(3'd3, 32'hD4);
    check("R9 usr write hits live", sp, 32'hD4);
    wr_dr(3'd2, 32'hE5);
    rd_dr("R9 sys shadow write", 3'd2, 32'hE5);
    check("R9 live kept", sp, 32'hD4);
    wr_cond(8'h20);
    check("R8 same select live", sp, 32'hD4);
    rd_dr("R8 same select sys", 3'd2, 32'hE5);
    wr_cond(8'h00);
    check("R7 live from system", sp, 32'hE5);
    rd_dr("R7 user shadow saved", 3'd3, 32'hD4);
    wr_cond(8'h00);
    check("R8 same zero live", sp, 32'hE5);
    @(negedge clk); psw_we = 1; psw_wd = 32'h0000_0020; sp_we = 1; sp_wd = 32'hF6; step();
    check("R11 direct wins", sp, 32'hF6);
    rd_dr("R11 sys gets old live", 3'd2, 32'hE5);
    rd_dr("R11 usr reads live", 3'd3, 32'hF6);
  endtask

  task automatic t_plain();
    wr_dr(3'd0, 32'h1111_0000);
    wr_dr(3'd1, 32'h2222_0000);
    wr_dr(3'd4, 32'h4444_0000);
    wr_dr(3'd5, 32'h5555_0000);
    wr_dr(3'd6, 32'h6666_0000);
    wr_dr(3'd7, 32'h7777_0000);
    rd_dr("R10 table base", 3'd0, 32'h1111_0000);
    rd_dr("R10 return ptr", 3'd1, 32'h2222_0000);
    rd_dr("R10 muldiv high", 3'd4, 32'h4444_0000);
    rd_dr("R10 muldiv low", 3'd5, 32'h5555_0000);
    rd_dr("R10 code 6 zero", 3'd6, 32'h0);
    rd_dr("R10 code 7 zero", 3'd7, 32'h0);
    check("R10 live unchanged", sp, 32'hF6);
    rd_dr("R10 sys unchanged", 3'd2, 32'hE5);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_word();
    t_fields();
    t_stack();
    t_plain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule